// File: doc/BRIEF.md
# Transactional Read/Write-Set Tracker

This block follows the read set and the write set of one hardware transaction inside a small, direct-mapped private data cache, and it decides when that transaction has to be thrown away. It holds, per cache line, a valid flag, a stored tag, a speculative-read mark and a speculative-write mark. It also watches four streams of events. The first is the begin/commit/abort commands from the core. The second is the core's own loads and stores, given as line addresses. The third is eviction notices from the cache. The fourth is coherence probes from other agents, each one marked as either a shared read or an invalidating write.

Stores made inside a transaction stay in the private cache and are never published before commit. A probe that collides with the marks is answered in its own cycle, and the remote requester always wins. The local transaction is then aborted in a single cycle: speculatively written lines are dropped and every mark is cleared. A commit clears every mark in a single cycle and leaves the buffered lines as ordinary data. The core's register checkpoint is represented only by a save strobe when a transaction starts and a restore strobe when one aborts.

A line address splits into a line index (its low `IDX_W` bits) and a tag (the remaining high bits).

Top module: `txn_set_tracker`

## Requirements
- R1: After reset no line is valid, no write mark is set, no transaction is active, and `abort_o`, `ckpt_save_o`, `ckpt_restore_o` are low with `abort_reason_o` = 0.
- R2: `cmd_i` encodes 0 = none, 1 = begin, 2 = commit, 3 = abort. A begin while idle makes `txn_active_o` high and pulses `ckpt_save_o` for one cycle, both visible after the next clock edge. A begin while a transaction is already active has no effect and gives no save pulse.
- R3: Any access installs its line: the index field selects the line, and the line becomes valid with the access tag. While a transaction is active, a load sets that line's read mark and a store sets its write mark, which is visible on `line_spec_dirty_o` after the edge. Accesses in the cycle that begin is issued are not transactional.
- R4: When no transaction is active, accesses set no marks, and probes never raise `probe_conflict_o` or an abort.
- R5: A probe hits when its line is valid and its tag matches. During a transaction, `probe_conflict_o` is high in the same cycle as the probe when a write probe hits a line with either mark set, or a read probe hits a line with the write mark set. A read probe that hits a line with only the read mark set, and any probe that misses, is not a conflict.
- R6: `abort_reason_o` encodes 0 = none, 1 = conflict, 2 = capacity/eviction, 3 = software. A conflicting probe gives, one edge later, a one-cycle `abort_o` with reason 1 and a one-cycle `ckpt_restore_o`, and the transaction ends.
- R7: During a transaction, an eviction notice for a line with a mark set, or an access that would replace a marked valid line with a different tag, aborts with reason 2. An eviction notice always invalidates its line.
- R8: An abort command during a transaction aborts with reason 3. Commit and abort commands while idle have no effect.
- R9: Any abort invalidates every line whose write mark was set, keeps lines that held only read marks valid, clears all marks, and drops any access issued in the same cycle. All of this happens in one cycle.
- R10: A commit with no abort cause clears all marks in one cycle, keeps every line valid, raises no abort, and ends the transaction.
- R11: A commit and a conflicting probe in the same cycle give an abort with reason 1 instead of a commit.
- R12: When several abort causes occur in the same cycle, the reason is chosen in the order conflict, then capacity, then software. `abort_reason_o` is 0 whenever `abort_o` is low.
- R13: A write probe that hits invalidates the local copy of that line, whether or not a transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Transaction command (0 none, 1 begin, 2 commit, 3 abort) |
| acc_valid_i | input | 1 | Core access present |
| acc_store_i | input | 1 | Access is a store (else a load) |
| acc_addr_i | input | LINE_ADDR_W | Line address of the core access |
| evict_valid_i | input | 1 | Eviction notice present |
| evict_idx_i | input | IDX_W | Index of the line being evicted |
| probe_valid_i | input | 1 | Incoming coherence probe present |
| probe_write_i | input | 1 | Probe is an invalidating write (else a read) |
| probe_addr_i | input | LINE_ADDR_W | Line address of the probe |
| probe_conflict_o | output | 1 | Probe collides with the transaction's marks (same cycle) |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_reason_o | output | 2 | Abort reason code |
| ckpt_save_o | output | 1 | Register checkpoint save strobe |
| ckpt_restore_o | output | 1 | Register checkpoint restore strobe |
| txn_active_o | output | 1 | A transaction is open |
| line_valid_o | output | NUM_LINES | Per-line valid flags |
| line_spec_dirty_o | output | NUM_LINES | Per-line speculative write marks |

## Verification
`probe_conflict_o` is the only combinational result. It is due in the same cycle as the probe, so the bench drives each stimulus just after a falling edge and samples that output one nanosecond later. Every other output comes from a register and is due one rising edge after the stimulus: the abort pulse and reason, both checkpoint strobes, `txn_active_o`, and the per-line valid and dirty vectors. The bench reads all of these at the falling edge that follows, before it drives the next stimulus. A reference model in the bench, written from the requirements, advances once per stimulus, so each expected value lines up with the cycle in which it is due. The bench compares every output against the model in every cycle, both in the directed corner cases and in the random traffic.

// File: rtl/txtrk_pkg.sv
package txtrk_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_BEGIN  = 2'd1,
        CMD_COMMIT = 2'd2,
        CMD_ABORT  = 2'd3
    } txn_cmd_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_CONFLICT = 2'd1,
        RSN_CAPACITY = 2'd2,
        RSN_SOFTWARE = 2'd3
    } abort_rsn_e;

    typedef struct packed {
        logic conflict;
        logic capacity;
        logic software;
    } abort_cause_t;

    // Fixed ranking: remote collision first, then lost footprint, then request.
    function automatic abort_rsn_e rank_cause(abort_cause_t c);
        if (c.conflict)      return RSN_CONFLICT;
        else if (c.capacity) return RSN_CAPACITY;
        else if (c.software) return RSN_SOFTWARE;
        else                 return RSN_NONE;
    endfunction

    // A remote writer collides with any mark, a remote reader only with a write mark.
    function automatic logic probe_clash(logic remote_wr, logic rmark, logic wmark);
        return remote_wr ? (rmark | wmark) : wmark;
    endfunction

endpackage

// File: rtl/txtrk_lookup.sv
module txtrk_lookup
    import txtrk_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                            txn_active_i,
    input  logic [NUM_LINES-1:0]            valid_i,
    input  logic [NUM_LINES-1:0]            rmark_i,
    input  logic [NUM_LINES-1:0]            wmark_i,
    input  logic [NUM_LINES-1:0][TAG_W-1:0] tag_i,
    input  logic                            probe_valid_i,
    input  logic                            probe_write_i,
    input  logic [IDX_W-1:0]                probe_idx_i,
    input  logic [TAG_W-1:0]                probe_tag_i,
    input  logic                            acc_valid_i,
    input  logic [IDX_W-1:0]                acc_idx_i,
    input  logic [TAG_W-1:0]                acc_tag_i,
    input  logic                            evict_valid_i,
    input  logic [IDX_W-1:0]                evict_idx_i,
    output logic                            probe_hit_o,
    output logic                            conflict_o,
    output logic                            capacity_o
);

    logic [NUM_LINES-1:0] marked;
    logic                 evict_marked;
    logic                 displace_marked;

    assign marked = rmark_i | wmark_i;

    assign probe_hit_o = probe_valid_i && valid_i[probe_idx_i]
                         && (tag_i[probe_idx_i] == probe_tag_i);

    assign conflict_o = txn_active_i && probe_hit_o
                        && probe_clash(probe_write_i, rmark_i[probe_idx_i], wmark_i[probe_idx_i]);

    assign evict_marked    = evict_valid_i && marked[evict_idx_i];
    assign displace_marked = acc_valid_i && valid_i[acc_idx_i]
                             && (tag_i[acc_idx_i] != acc_tag_i) && marked[acc_idx_i];

    assign capacity_o = txn_active_i && (evict_marked || displace_marked);

    // Footprint lookup: marks must not exist on invalid lines.
    always_comb begin
        p_marks_on_valid_r3: assert ((marked & ~valid_i) == '0)
            else $error("mark held by an invalid line");
    end

    always_comb begin
        p_readshare_ok_r5: assert (!(probe_hit_o && !probe_write_i && !wmark_i[probe_idx_i]) || !conflict_o)
            else $error("read probe on read-only line flagged");
    end

endmodule

// File: rtl/txtrk_line_array.sv
module txtrk_line_array
    import txtrk_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            txn_active_i,
    input  logic                            commit_i,
    input  logic                            abort_i,
    input  logic                            acc_valid_i,
    input  logic                            acc_store_i,
    input  logic [IDX_W-1:0]                acc_idx_i,
    input  logic [TAG_W-1:0]                acc_tag_i,
    input  logic                            evict_valid_i,
    input  logic [IDX_W-1:0]                evict_idx_i,
    input  logic                            probe_inv_i,
    input  logic [IDX_W-1:0]                probe_idx_i,
    output logic [NUM_LINES-1:0]            valid_o,
    output logic [NUM_LINES-1:0]            rmark_o,
    output logic [NUM_LINES-1:0]            wmark_o,
    output logic [NUM_LINES-1:0][TAG_W-1:0] tag_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic             hit_acc, hit_evict, hit_probe, same_line;
        logic             v_d, r_d, w_d;
        logic [TAG_W-1:0] t_d;

        assign hit_acc   = acc_valid_i   && (acc_idx_i   == IDX_W'(i));
        assign hit_evict = evict_valid_i && (evict_idx_i == IDX_W'(i));
        assign hit_probe = probe_inv_i   && (probe_idx_i == IDX_W'(i));
        assign same_line = valid_o[i] && (tag_o[i] == acc_tag_i);

        always_comb begin
            v_d = valid_o[i];
            r_d = rmark_o[i];
            w_d = wmark_o[i];
            t_d = tag_o[i];
            if (abort_i) begin
                // speculative data is discarded; read-only lines survive
                if (wmark_o[i]) v_d = 1'b0;
                r_d = 1'b0;
                w_d = 1'b0;
            end else begin
                if (commit_i) begin
                    r_d = 1'b0;
                    w_d = 1'b0;
                end
                if (hit_acc) begin
                    if (!same_line) begin
                        r_d = 1'b0;
                        w_d = 1'b0;
                        t_d = acc_tag_i;
                    end
                    v_d = 1'b1;
                    if (txn_active_i && !commit_i) begin
                        r_d = r_d | ~acc_store_i;
                        w_d = w_d |  acc_store_i;
                    end
                end
            end
            if (hit_evict || hit_probe) begin
                v_d = 1'b0;
                r_d = 1'b0;
                w_d = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_o[i] <= 1'b0;
                rmark_o[i] <= 1'b0;
                wmark_o[i] <= 1'b0;
                tag_o[i]   <= '0;
            end else begin
                valid_o[i] <= v_d;
                rmark_o[i] <= r_d;
                wmark_o[i] <= w_d;
                tag_o[i]   <= t_d;
            end
        end
    end

    p_commit_flash_r10: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> (rmark_o == '0 && wmark_o == '0))
        else $error("marks survive commit");

    p_abort_drops_spec_r9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (rmark_o == '0 && wmark_o == '0 && (valid_o & $past(wmark_o)) == '0))
        else $error("speculative line survives abort");

    p_idle_no_marks_r4: assert property (@(posedge clk) disable iff (rst)
        (!txn_active_i && !abort_i && !commit_i && rmark_o == '0 && wmark_o == '0)
            |=> (rmark_o == '0 && wmark_o == '0))
        else $error("mark set outside a transaction");

endmodule

// File: rtl/txtrk_ctrl.sv
module txtrk_ctrl
    import txtrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_i,
    input  logic       conflict_i,
    input  logic       capacity_i,
    output logic       active_o,
    output logic       commit_now_o,
    output logic       abort_now_o,
    output logic       abort_pulse_o,
    output logic [1:0] reason_o,
    output logic       save_o,
    output logic       restore_o
);

    txn_cmd_e     cmd;
    abort_cause_t cause;
    abort_rsn_e   rsn_d, rsn_q;
    logic         begin_now;

    assign cmd = txn_cmd_e'(cmd_i);

    assign cause.conflict = conflict_i;
    assign cause.capacity = capacity_i;
    assign cause.software = active_o && (cmd == CMD_ABORT);

    assign abort_now_o  = cause.conflict | cause.capacity | cause.software;
    assign commit_now_o = active_o && (cmd == CMD_COMMIT) && !abort_now_o;
    assign begin_now    = !active_o && (cmd == CMD_BEGIN);
    assign rsn_d        = rank_cause(cause);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o      <= 1'b0;
            abort_pulse_o <= 1'b0;
            rsn_q         <= RSN_NONE;
            save_o        <= 1'b0;
            restore_o     <= 1'b0;
        end else begin
            if (begin_now)                        active_o <= 1'b1;
            else if (abort_now_o || commit_now_o) active_o <= 1'b0;
            abort_pulse_o <= abort_now_o;
            rsn_q         <= rsn_d;
            save_o        <= begin_now;
            restore_o     <= abort_now_o;
        end
    end

    assign reason_o = rsn_q;

    p_reason_tracks_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (abort_pulse_o == (reason_o != 2'd0)))
        else $error("reason and abort pulse disagree");

    p_abort_closes_txn_r6: assert property (@(posedge clk) disable iff (rst)
        abort_pulse_o |-> !active_o)
        else $error("transaction open after abort");

    p_save_opens_txn_r2: assert property (@(posedge clk) disable iff (rst)
        save_o |-> (active_o && !$past(active_o)))
        else $error("save strobe without a fresh transaction");

    p_no_cause_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> !(conflict_i || capacity_i))
        else $error("abort cause raised while idle");

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
    import txtrk_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int LINE_ADDR_W = 12,
    localparam int IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             cmd_i,
    input  logic                   acc_valid_i,
    input  logic                   acc_store_i,
    input  logic [LINE_ADDR_W-1:0] acc_addr_i,
    input  logic                   evict_valid_i,
    input  logic [IDX_W-1:0]       evict_idx_i,
    input  logic                   probe_valid_i,
    input  logic                   probe_write_i,
    input  logic [LINE_ADDR_W-1:0] probe_addr_i,
    output logic                   probe_conflict_o,
    output logic                   abort_o,
    output logic [1:0]             abort_reason_o,
    output logic                   ckpt_save_o,
    output logic                   ckpt_restore_o,
    output logic                   txn_active_o,
    output logic [NUM_LINES-1:0]   line_valid_o,
    output logic [NUM_LINES-1:0]   line_spec_dirty_o
);

    localparam int TAG_W = LINE_ADDR_W - IDX_W;

    logic [IDX_W-1:0]                acc_idx, probe_idx;
    logic [TAG_W-1:0]                acc_tag, probe_tag;
    logic [NUM_LINES-1:0]            valid, rmark, wmark;
    logic [NUM_LINES-1:0][TAG_W-1:0] tags;
    logic                            probe_hit, conflict, capacity;
    logic                            commit_now, abort_now;

    assign acc_idx   = acc_addr_i[IDX_W-1:0];
    assign acc_tag   = acc_addr_i[LINE_ADDR_W-1:IDX_W];
    assign probe_idx = probe_addr_i[IDX_W-1:0];
    assign probe_tag = probe_addr_i[LINE_ADDR_W-1:IDX_W];

    txtrk_lookup #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_lookup (
        .txn_active_i  (txn_active_o),
        .valid_i       (valid),
        .rmark_i       (rmark),
        .wmark_i       (wmark),
        .tag_i         (tags),
        .probe_valid_i (probe_valid_i),
        .probe_write_i (probe_write_i),
        .probe_idx_i   (probe_idx),
        .probe_tag_i   (probe_tag),
        .acc_valid_i   (acc_valid_i),
        .acc_idx_i     (acc_idx),
        .acc_tag_i     (acc_tag),
        .evict_valid_i (evict_valid_i),
        .evict_idx_i   (evict_idx_i),
        .probe_hit_o   (probe_hit),
        .conflict_o    (conflict),
        .capacity_o    (capacity)
    );

    txtrk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cmd_i         (cmd_i),
        .conflict_i    (conflict),
        .capacity_i    (capacity),
        .active_o      (txn_active_o),
        .commit_now_o  (commit_now),
        .abort_now_o   (abort_now),
        .abort_pulse_o (abort_o),
        .reason_o      (abort_reason_o),
        .save_o        (ckpt_save_o),
        .restore_o     (ckpt_restore_o)
    );

    txtrk_line_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_lines (
        .clk           (clk),
        .rst           (rst),
        .txn_active_i  (txn_active_o),
        .commit_i      (commit_now),
        .abort_i       (abort_now),
        .acc_valid_i   (acc_valid_i),
        .acc_store_i   (acc_store_i),
        .acc_idx_i     (acc_idx),
        .acc_tag_i     (acc_tag),
        .evict_valid_i (evict_valid_i),
        .evict_idx_i   (evict_idx_i),
        .probe_inv_i   (probe_hit && probe_write_i),
        .probe_idx_i   (probe_idx),
        .valid_o       (valid),
        .rmark_o       (rmark),
        .wmark_o       (wmark),
        .tag_o         (tags)
    );

    assign probe_conflict_o  = conflict;
    assign line_valid_o      = valid;
    assign line_spec_dirty_o = wmark;

    p_conflict_aborts_r6: assert property (@(posedge clk) disable iff (rst)
        probe_conflict_o |=> (abort_o && abort_reason_o == 2'd1 && ckpt_restore_o))
        else $error("conflict without abort");

    p_remote_write_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (probe_hit && probe_write_i) |=> !line_valid_o[$past(probe_idx)])
        else $error("line kept after remote write");

endmodule

// File: tb/txn_set_tracker_bench.sv
`timescale 1ns/1ps
module txn_set_tracker_bench;

    localparam int NL = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cmd;
    logic          av, ast, ev, pv, pw;
    logic [AW-1:0] aa, pa;
    logic [3:0]    ei;
    logic          pconf, ab_o, save_o, rest_o, act_o;
    logic [1:0]    rsn_o;
    logic [NL-1:0] val_o, dirty_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    logic          mv [NL];
    logic          mr [NL];
    logic          mw [NL];
    logic [7:0]    mt [NL];
    logic          mact;
    logic          e_ab, e_save, e_rest;
    logic [1:0]    e_rsn;

    always #4 clk = ~clk;

    txn_set_tracker u_txn_set_tracker (
        .clk(clk), .rst(rst), .cmd_i(cmd),
        .acc_valid_i(av), .acc_store_i(ast), .acc_addr_i(aa),
        .evict_valid_i(ev), .evict_idx_i(ei),
        .probe_valid_i(pv), .probe_write_i(pw), .probe_addr_i(pa),
        .probe_conflict_o(pconf), .abort_o(ab_o), .abort_reason_o(rsn_o),
        .ckpt_save_o(save_o), .ckpt_restore_o(rest_o), .txn_active_o(act_o),
        .line_valid_o(val_o), .line_spec_dirty_o(dirty_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] pack_v();
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) r[i] = mv[i];
        return r;
    endfunction

    function automatic logic [NL-1:0] pack_w();
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) r[i] = mw[i];
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin
            mv[i] = 0; mr[i] = 0; mw[i] = 0; mt[i] = '0;
        end
        mact = 0; e_ab = 0; e_save = 0; e_rest = 0; e_rsn = 0;
    endtask

    task automatic check_regs(string req);
        chk(req, "line_valid",   32'(val_o),   32'(pack_v()));
        chk(req, "spec_dirty",   32'(dirty_o), 32'(pack_w()));
        chk(req, "txn_active",   32'(act_o),   32'(mact));
        chk(req, "abort",        32'(ab_o),    32'(e_ab));
        chk(req, "abort_reason", 32'(rsn_o),   32'(e_rsn));
        chk(req, "ckpt_save",    32'(save_o),  32'(e_save));
        chk(req, "ckpt_restore", 32'(rest_o),  32'(e_rest));
    endtask

    // Drive one cycle of stimulus, check the same-cycle response and the registered results.
    task automatic apply(input logic [1:0] c, input logic a_v, input logic a_s, input logic [AW-1:0] a_a,
                         input logic e_v, input logic [3:0] e_i,
                         input logic p_v, input logic p_w, input logic [AW-1:0] p_a, input string req);
        logic [3:0] pi, ai;
        logic [7:0] ptg, atg;
        logic phit, conf, cap, sw, abn, cmt, bgn;
        cmd = c; av = a_v; ast = a_s; aa = a_a; ev = e_v; ei = e_i; pv = p_v; pw = p_w; pa = p_a;
        pi = p_a[3:0]; ptg = p_a[11:4]; ai = a_a[3:0]; atg = a_a[11:4];
        phit = p_v && mv[pi] && (mt[pi] == ptg);
        conf = mact && phit && (p_w ? (mr[pi] | mw[pi]) : mw[pi]);
        cap  = mact && ((e_v && (mr[e_i] | mw[e_i]))
                     || (a_v && mv[ai] && (mt[ai] != atg) && (mr[ai] | mw[ai])));
        sw   = mact && (c == 2'd3);
        abn  = conf | cap | sw;
        cmt  = mact && (c == 2'd2) && !abn;
        bgn  = !mact && (c == 2'd1);
        #1;
        chk(req, "probe_conflict", 32'(pconf), 32'(conf));
        if (abn) begin
            for (int i = 0; i < NL; i++) begin
                if (mw[i]) mv[i] = 0;
                mr[i] = 0; mw[i] = 0;
            end
        end else begin
            if (cmt) for (int i = 0; i < NL; i++) begin mr[i] = 0; mw[i] = 0; end
            if (a_v) begin
                if (!(mv[ai] && mt[ai] == atg)) begin mr[ai] = 0; mw[ai] = 0; mt[ai] = atg; end
                mv[ai] = 1;
                if (mact && !cmt) begin
                    if (a_s) mw[ai] = 1; else mr[ai] = 1;
                end
            end
        end
        if (e_v) begin mv[e_i] = 0; mr[e_i] = 0; mw[e_i] = 0; end
        if (phit && p_w) begin mv[pi] = 0; mr[pi] = 0; mw[pi] = 0; end
        e_ab = abn; e_rest = abn; e_save = bgn;
        e_rsn = conf ? 2'd1 : cap ? 2'd2 : sw ? 2'd3 : 2'd0;
        if (bgn) mact = 1; else if (abn || cmt) mact = 0;
        @(posedge clk);
        @(negedge clk);
        check_regs(req);
    endtask

    task automatic cmd_only(input logic [1:0] c, input string req);
        apply(c, 0, 0, '0, 0, '0, 0, 0, '0, req);
    endtask

    task automatic access(input logic st, input logic [AW-1:0] a, input string req);
        apply(2'd0, 1, st, a, 0, '0, 0, 0, '0, req);
    endtask

    task automatic probe(input logic wr, input logic [AW-1:0] a, input string req);
        apply(2'd0, 0, 0, '0, 0, '0, 1, wr, a, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        cmd = 0; av = 0; ast = 0; aa = '0; ev = 0; ei = '0; pv = 0; pw = 0; pa = '0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_regs("R1");

        // R2: begin opens, second begin ignored
        cmd_only(2'd1, "R2");
        chk("R2", "save pulse", 32'(save_o), 32'd1);
        cmd_only(2'd1, "R2");
        chk("R2", "no second save", 32'(save_o), 32'd0);

        // R3 / R5: load idx1, store idx2, read-share, miss, write-conflict
        access(0, 12'h001, "R3");
        access(1, 12'h002, "R3");
        chk("R3", "dirty idx2", 32'(dirty_o[2]), 32'd1);
        probe(0, 12'h001, "R5");
        probe(0, 12'h012, "R5");
        apply(2'd0, 0, 0, '0, 0, '0, 1, 0, 12'h002, "R5");
        chk("R6", "reason conflict", 32'(rsn_o), 32'd1);
        chk("R9", "dirty line dropped", 32'(val_o[2]), 32'd0);
        chk("R9", "read line kept", 32'(val_o[1]), 32'd1);

        // R8 / R9: software abort
        cmd_only(2'd1, "R8");
        access(1, 12'h003, "R8");
        access(0, 12'h004, "R8");
        apply(2'd3, 1, 1, 12'h00B, 0, '0, 0, 0, '0, "R9");
        chk("R8", "reason software", 32'(rsn_o), 32'd3);
        chk("R9", "access dropped on abort", 32'(val_o[11]), 32'd0);
        cmd_only(2'd3, "R8");
        cmd_only(2'd2, "R8");

        // R10: commit keeps data
        cmd_only(2'd1, "R10");
        access(1, 12'h005, "R10");
        cmd_only(2'd2, "R10");
        chk("R10", "line kept", 32'(val_o[5]), 32'd1);

        // R4 / R13: idle accesses and probes
        access(1, 12'h006, "R4");
        probe(1, 12'h006, "R4");
        chk("R13", "remote write invalidates", 32'(val_o[6]), 32'd0);

        // R7: eviction and displacement of marked lines
        cmd_only(2'd1, "R7");
        access(0, 12'h007, "R7");
        apply(2'd0, 0, 0, '0, 1, 4'd7, 0, 0, '0, "R7");
        chk("R7", "reason capacity", 32'(rsn_o), 32'd2);
        cmd_only(2'd1, "R7");
        access(1, 12'h008, "R7");
        access(0, 12'h018, "R7");
        chk("R7", "displacement abort", 32'(rsn_o), 32'd2);

        // R11: commit with conflicting probe
        cmd_only(2'd1, "R11");
        access(1, 12'h009, "R11");
        apply(2'd2, 0, 0, '0, 0, '0, 1, 0, 12'h009, "R11");
        chk("R11", "probe beats commit", 32'(rsn_o), 32'd1);

        // R12: all three causes together
        cmd_only(2'd1, "R12");
        access(0, 12'h00A, "R12");
        apply(2'd3, 0, 0, '0, 1, 4'd10, 1, 1, 12'h00A, "R12");
        chk("R12", "conflict ranks first", 32'(rsn_o), 32'd1);
        cmd_only(2'd1, "R12");
        access(0, 12'h00C, "R12");
        apply(2'd3, 0, 0, '0, 1, 4'd12, 0, 0, '0, "R12");
        chk("R12", "capacity over software", 32'(rsn_o), 32'd2);

        // random traffic, every output against the model (R3 R5 R6 R7 R9 R10)
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] c;
            int k;
            k = int'($urandom % 20);
            c = (k == 0) ? 2'd1 : (k == 1) ? 2'd2 : (k == 2) ? 2'd3 : 2'd0;
            if (!mact && ($urandom % 3 == 0)) c = 2'd1;
            apply(c, ($urandom % 2) == 1, ($urandom % 2) == 1, {8'($urandom % 2), 4'($urandom)},
                  ($urandom % 12) == 0, 4'($urandom),
                  ($urandom % 4) == 0, ($urandom % 2) == 1, {8'($urandom % 2), 4'($urandom)},
                  "R5");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule